// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block owns a small shared word-addressed memory and serves a fixed number of requesters. Each requester presents an operation code, a word address and a write value. It holds them until its grant bit rises. In the cycle after the grant the block returns a response: the word that was read and a status bit. Plain loads and stores pass through it. So do indivisible read-modify-write primitives: swap, fetch-and-increment and test-and-set. Each of these reads a word and writes it back within the same granted cycle, so no other access can fall between the read and the write.

A load-linked / store-conditional pair is also provided. Each requester has a reservation monitor, built as a two-state machine with states `RSV_IDLE` and `RSV_HELD`. Four transitions move it:
- LINK: `RSV_IDLE` to `RSV_HELD` on the requester's own granted load-linked.
- RELINK: `RSV_HELD` to `RSV_HELD` on a further load-linked, which replaces the reserved address.
- SC_DROP: `RSV_HELD` to `RSV_IDLE` on the requester's own store-conditional.
- SNOOP_DROP: `RSV_HELD` to `RSV_IDLE` when another requester writes the reserved word.

A store-conditional writes only while its requester is in `RSV_HELD` for the same address. A round-robin arbiter admits one operation per cycle.

Operation codes on `req_op`: 0 load, 1 store, 2 test-and-set, 3 swap, 4 fetch-and-increment, 5 load-linked, 6 store-conditional. Code 7 behaves as a load.

Top module: `amo_unit`

## Requirements
- R1: A load returns the addressed word with status 1. A store writes the value and returns data 0 with status 1. Every operation other than store-conditional returns status 1.
- R2: A swap returns the word's previous contents and leaves the requester's value in the word.
- R3: A fetch-and-increment returns the previous contents and leaves the previous contents plus one, wrapping modulo 2^DW.
- R4: A test-and-set returns the previous contents and leaves the value 1 in the word.
- R5: A load-linked returns the word and reserves its address. A following store-conditional to that address, with no intervening write by another requester, writes the value and returns status 1 with data 0.
- R6: A store-conditional without a reservation, or to an address other than the reserved one, returns status 0 and data 0 and leaves memory unchanged.
- R7: A reservation is cancelled by any write to the reserved address from another requester (store, swap, fetch-and-increment, test-and-set, successful store-conditional). The owner's own writes do not cancel it, and neither do writes to other addresses.
- R8: A requester's own store-conditional cancels its reservation whether it passes or fails. A new load-linked replaces the earlier reserved address.
- R9: At most one grant is raised per cycle, and only to a requester with `req_valid` set. After requester i is granted, the search for the next grant starts at i+1 and wraps around.
- R10: `rsp_valid[i]` is high in exactly the cycle after the cycle in which `gnt[i]` was high.
- R11: After reset every word reads 0, no reservation is held, no response is valid, and requester 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_op | input | NREQ x 3 | Operation code per requester |
| req_addr | input | NREQ x AW | Word address per requester |
| req_wdata | input | NREQ x DW | Write value per requester |
| gnt | output | NREQ | One-hot grant, combinational from the requests |
| rsp_valid | output | NREQ | Response valid, one cycle after the grant |
| rsp_data | output | NREQ x DW | Returned word per requester |
| rsp_status | output | NREQ | Status bit (store-conditional success, otherwise 1) |

## Verification
The hardest situation to reach from the ports is two reservations on the same word. In this case one requester's store-conditional succeeds and must silently cancel the other's link, so the second store-conditional fails. Directed sequences build this interleaving explicitly. They also cover the cases that must leave a link intact: the owner's own store, and another requester's write to a different word. The random phase then confines addresses to four words so that links and snoops collide often, and compares every response against a reference model in the bench that tracks memory, reservations and the arbitration pointer.

// File: rtl/amo_pkg.sv
package amo_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_FINC  = 3'd4,
        OP_LL    = 3'd5,
        OP_SC    = 3'd6,
        OP_RSVD  = 3'd7
    } amo_op_t;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_t;
endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int NREQ = 4,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic [IW-1:0]   gidx,
    output logic            any
);
    logic [IW-1:0] last_q;

    // search starts one past the last winner
    always_comb begin
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        for (int k = 1; k <= NREQ; k++) begin
            int c;
            c = (int'(last_q) + k) % NREQ;
            if (!any && req[c]) begin
                any    = 1'b1;
                gnt[c] = 1'b1;
                gidx   = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(NREQ - 1);
        else if (any)
            last_q <= gidx;
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv
    import amo_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int IDX  = 0,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_link,
    input  logic          own_sc,
    input  logic [AW-1:0] link_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] wr_src,
    input  logic [AW-1:0] chk_addr,
    output logic          held,
    output logic          sc_ok
);
    rsv_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          snoop_hit;

    assign snoop_hit = wr_en && (wr_src != IW'(IDX)) && (wr_addr == addr_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_IDLE: if (set_link) state_d = RSV_HELD;          // LINK
            RSV_HELD: begin
                if (set_link)       state_d = RSV_HELD;          // RELINK
                else if (own_sc)    state_d = RSV_IDLE;          // SC_DROP
                else if (snoop_hit) state_d = RSV_IDLE;          // SNOOP_DROP
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (set_link) addr_q <= link_addr;
        end
    end

    always_comb begin
        held  = (state_q == RSV_HELD);
        sc_ok = held && (addr_q == chk_addr);
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREQ-1:0]          req_valid,
    input  logic [NREQ-1:0][2:0]     req_op,
    input  logic [NREQ-1:0][AW-1:0]  req_addr,
    input  logic [NREQ-1:0][DW-1:0]  req_wdata,
    output logic [NREQ-1:0]          gnt,
    output logic [NREQ-1:0]          rsp_valid,
    output logic [NREQ-1:0][DW-1:0]  rsp_data,
    output logic [NREQ-1:0]          rsp_status
);
    localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]   mem [DEPTH];
    logic [IW-1:0]   gidx;
    logic            any;
    logic [NREQ-1:0] resv_held;
    logic [NREQ-1:0] resv_ok;

    amo_op_t       cur_op;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata, old_word, new_word, ret_data;
    logic          mem_we, ret_status;

    amo_arbiter #(.NREQ(NREQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid),
        .gnt(gnt), .gidx(gidx), .any(any)
    );

    for (genvar i = 0; i < NREQ; i++) begin : g_resv
        amo_resv #(.NREQ(NREQ), .AW(AW), .IDX(i)) u_resv (
            .clk(clk), .rst_n(rst_n),
            .set_link(gnt[i] && (req_op[i] == OP_LL)),
            .own_sc(gnt[i] && (req_op[i] == OP_SC)),
            .link_addr(req_addr[i]),
            .wr_en(mem_we), .wr_addr(cur_addr), .wr_src(gidx),
            .chk_addr(req_addr[i]),
            .held(resv_held[i]), .sc_ok(resv_ok[i])
        );
    end

    // execute the granted operation within the cycle
    always_comb begin
        cur_op     = amo_op_t'(req_op[gidx]);
        cur_addr   = req_addr[gidx];
        cur_wdata  = req_wdata[gidx];
        old_word   = mem[cur_addr];
        new_word   = old_word;
        mem_we     = 1'b0;
        ret_data   = old_word;
        ret_status = 1'b1;
        unique case (cur_op)
            OP_STORE: begin mem_we = any; new_word = cur_wdata; ret_data = '0; end
            OP_TAS:   begin mem_we = any; new_word = DW'(1); end
            OP_SWAP:  begin mem_we = any; new_word = cur_wdata; end
            OP_FINC:  begin mem_we = any; new_word = old_word + DW'(1); end
            OP_SC: begin
                ret_data   = '0;
                ret_status = resv_ok[gidx];
                mem_we     = any && resv_ok[gidx];
                new_word   = cur_wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            rsp_valid  <= '0;
            rsp_data   <= '0;
            rsp_status <= '0;
        end else begin
            if (mem_we) mem[cur_addr] <= new_word;
            rsp_valid <= gnt;
            if (any) begin
                rsp_data[gidx]   <= ret_data;
                rsp_status[gidx] <= ret_status;
            end
        end
    end
endmodule

// File: rtl/amo_checker.sv
module amo_checker
    import amo_pkg::*;
#(
    parameter int NREQ = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NREQ-1:0]      req_valid,
    input logic [NREQ-1:0][2:0] req_op,
    input logic [NREQ-1:0]      gnt,
    input logic [NREQ-1:0]      rsp_valid,
    input logic [NREQ-1:0]      rsp_status,
    input logic [NREQ-1:0]      held
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R9
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req_valid) == '0); // R9
    AST_RSP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> rsp_valid == $past(gnt)); // R10

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        AST_SC_CLEARS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && req_op[i] == OP_SC) |=> !held[i]); // R8
        AST_LL_SETS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && req_op[i] == OP_LL) |=> held[i]); // R5
        AST_PLAIN_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && req_op[i] != OP_SC) |=> rsp_status[i]); // R1
    end
endmodule

bind amo_unit amo_checker #(.NREQ(NREQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .gnt(gnt), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .held(resv_held)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
    import amo_pkg::*;
    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0]          req_valid;
    logic [NREQ-1:0][2:0]     req_op;
    logic [NREQ-1:0][AW-1:0]  req_addr;
    logic [NREQ-1:0][DW-1:0]  req_wdata;
    logic [NREQ-1:0]          gnt, rsp_valid, rsp_status;
    logic [NREQ-1:0][DW-1:0]  rsp_data;

    always #2.5 clk = ~clk;

    amo_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status)
    );

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // pending request slots
    bit          p_v  [NREQ];
    logic [2:0]  p_op [NREQ];
    logic [AW-1:0] p_a [NREQ];
    logic [DW-1:0] p_d [NREQ];
    // reference model state
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_held [NREQ];
    logic [AW-1:0] m_raddr [NREQ];
    int            m_last;
    // expected responses
    bit          e_rv [NREQ];
    logic [DW-1:0] e_d [NREQ];
    bit          e_st [NREQ];
    logic [2:0]  e_op [NREQ];
    logic [DW-1:0] got_d [NREQ];
    bit          got_st [NREQ];

    function automatic string op_tag(logic [2:0] op);
        case (op)
            3'd2: return "R4";
            3'd3: return "R2";
            3'd4: return "R3";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
        for (int i = 0; i < NREQ; i++) begin
            m_held[i] = 0; m_raddr[i] = '0; e_rv[i] = 0; p_v[i] = 0;
        end
        m_last = NREQ - 1;
    endtask

    // one clock cycle, called at a falling edge
    task automatic step();
        int g;
        logic [NREQ-1:0] eg;
        for (int i = 0; i < NREQ; i++) begin
            chk(rsp_valid[i] == e_rv[i], "R10", rsp_valid[i], e_rv[i]);
            if (e_rv[i] && rsp_valid[i]) begin
                chk(rsp_data[i] == e_d[i], op_tag(e_op[i]), rsp_data[i], e_d[i]);
                chk(rsp_status[i] == e_st[i], op_tag(e_op[i]), rsp_status[i], e_st[i]);
                got_d[i] = rsp_data[i];
                got_st[i] = rsp_status[i];
            end
        end
        for (int i = 0; i < NREQ; i++) begin
            req_valid[i] = p_v[i];
            req_op[i]    = p_op[i];
            req_addr[i]  = p_a[i];
            req_wdata[i] = p_d[i];
        end
        #0.5;
        g = -1;
        eg = '0;
        for (int k = 1; k <= NREQ; k++) begin
            int c = (m_last + k) % NREQ;
            if (g < 0 && p_v[c]) g = c;
        end
        if (g >= 0) eg[g] = 1'b1;
        chk(gnt == eg, "R9", gnt, eg);
        for (int i = 0; i < NREQ; i++) e_rv[i] = 0;
        if (g >= 0) begin
            logic [DW-1:0] old;
            logic [AW-1:0] a;
            bit wr;
            logic [DW-1:0] nv;
            a = p_a[g];
            old = m_mem[a];
            wr = 0; nv = old;
            e_d[g] = old; e_st[g] = 1; e_op[g] = p_op[g];
            case (p_op[g])
                3'd1: begin wr = 1; nv = p_d[g]; e_d[g] = '0; end
                3'd2: begin wr = 1; nv = 1; end
                3'd3: begin wr = 1; nv = p_d[g]; end
                3'd4: begin wr = 1; nv = old + 1'b1; end
                3'd5: begin m_held[g] = 1; m_raddr[g] = a; end
                3'd6: begin
                    e_d[g] = '0;
                    e_st[g] = m_held[g] && (m_raddr[g] == a);
                    wr = e_st[g]; nv = p_d[g];
                    m_held[g] = 0;
                end
                default: ;
            endcase
            if (wr) begin
                m_mem[a] = nv;
                for (int j = 0; j < NREQ; j++)
                    if (j != g && m_held[j] && m_raddr[j] == a) m_held[j] = 0;
            end
            e_rv[g] = 1;
            p_v[g] = 0;
            m_last = g;
        end
        @(negedge clk);
    endtask

    task automatic do_op(int i, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
        p_v[i] = 1; p_op[i] = op; p_a[i] = a; p_d[i] = d;
        while (p_v[i]) step();
        step();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < NREQ; i++) begin p_op[i] = '0; p_a[i] = '0; p_d[i] = '0; end
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0, "R11", rsp_valid, 0);
        chk(gnt == '0, "R11", gnt, 0);

        do_op(2, OP_LOAD, 4'd9, 0);
        chk(got_d[2] == 0, "R11", got_d[2], 0);
        do_op(1, OP_SC, 4'd9, 16'h7777);
        chk(got_st[1] == 0, "R11", got_st[1], 0);

        do_op(0, OP_STORE, 4'd3, 16'h1234);
        do_op(1, OP_LOAD, 4'd3, 0);
        chk(got_d[1] == 16'h1234, "R1", got_d[1], 16'h1234);

        do_op(1, OP_SWAP, 4'd3, 16'hBEEF);
        chk(got_d[1] == 16'h1234, "R2", got_d[1], 16'h1234);
        do_op(0, OP_LOAD, 4'd3, 0);
        chk(got_d[0] == 16'hBEEF, "R2", got_d[0], 16'hBEEF);

        do_op(2, OP_FINC, 4'd3, 0);
        do_op(2, OP_LOAD, 4'd3, 0);
        chk(got_d[2] == 16'hBEF0, "R3", got_d[2], 16'hBEF0);
        do_op(3, OP_STORE, 4'd5, 16'hFFFF);
        do_op(3, OP_FINC, 4'd5, 0);
        do_op(3, OP_LOAD, 4'd5, 0);
        chk(got_d[3] == 0, "R3", got_d[3], 0);

        do_op(3, OP_TAS, 4'd6, 0);
        chk(got_d[3] == 0, "R4", got_d[3], 0);
        do_op(2, OP_TAS, 4'd6, 0);
        chk(got_d[2] == 1, "R4", got_d[2], 1);

        do_op(0, OP_LL, 4'd7, 0);
        do_op(0, OP_SC, 4'd7, 16'h0055);
        chk(got_st[0] == 1, "R5", got_st[0], 1);
        do_op(0, OP_SC, 4'd7, 16'h0066);
        chk(got_st[0] == 0, "R6", got_st[0], 0);
        do_op(0, OP_LOAD, 4'd7, 0);
        chk(got_d[0] == 16'h0055, "R6", got_d[0], 16'h0055);
        do_op(0, OP_LL, 4'd7, 0);
        do_op(0, OP_SC, 4'd8, 16'h0099);
        chk(got_st[0] == 0, "R6", got_st[0], 0);
        do_op(0, OP_LOAD, 4'd8, 0);
        chk(got_d[0] == 0, "R6", got_d[0], 0);

        // two links on one word; the second requester wins
        do_op(0, OP_LL, 4'd2, 0);
        do_op(1, OP_LL, 4'd2, 0);
        do_op(1, OP_SC, 4'd2, 16'h0011);
        chk(got_st[1] == 1, "R7", got_st[1], 1);
        do_op(0, OP_SC, 4'd2, 16'h0022);
        chk(got_st[0] == 0, "R7", got_st[0], 0);
        do_op(0, OP_LOAD, 4'd2, 0);
        chk(got_d[0] == 16'h0011, "R7", got_d[0], 16'h0011);
        do_op(0, OP_LL, 4'd2, 0);
        do_op(3, OP_STORE, 4'd2, 16'h0033);
        do_op(0, OP_SC, 4'd2, 16'h0044);
        chk(got_st[0] == 0, "R7", got_st[0], 0);
        do_op(0, OP_LL, 4'd2, 0);
        do_op(3, OP_STORE, 4'd4, 16'h0033);
        do_op(0, OP_SC, 4'd2, 16'h0044);
        chk(got_st[0] == 1, "R7", got_st[0], 1);
        do_op(0, OP_LL, 4'd2, 0);
        do_op(0, OP_STORE, 4'd2, 16'h0045);
        do_op(0, OP_SC, 4'd2, 16'h0046);
        chk(got_st[0] == 1, "R7", got_st[0], 1);

        do_op(0, OP_LL, 4'd2, 0);
        do_op(0, OP_LL, 4'd3, 0);
        do_op(0, OP_SC, 4'd2, 16'h0001);
        chk(got_st[0] == 0, "R8", got_st[0], 0);
        do_op(0, OP_LL, 4'd3, 0);
        do_op(0, OP_SC, 4'd3, 16'h0002);
        chk(got_st[0] == 1, "R8", got_st[0], 1);
        do_op(0, OP_SC, 4'd3, 16'h0003);
        chk(got_st[0] == 0, "R8", got_st[0], 0);

        // all requesters at once: rotation order is checked each cycle (R9)
        for (int i = 0; i < NREQ; i++) begin
            p_v[i] = 1; p_op[i] = OP_LOAD; p_a[i] = 4'(i); p_d[i] = '0;
        end
        repeat (NREQ + 1) step();

        // random phase over four words
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NREQ; i++) begin
                if (!p_v[i] && ($urandom % 2 == 0)) begin
                    p_v[i] = 1;
                    p_op[i] = 3'($urandom % 7);
                    p_a[i] = AW'($urandom % 4);
                    p_d[i] = DW'($urandom);
                end
            end
            step();
        end
        for (int i = 0; i < NREQ; i++) p_v[i] = 0;
        repeat (NREQ + 1) step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule